// File: doc/BRIEF.md
# Glitch-free CPU and bus clock stop controller

This block sits between a clock synthesizer and its output drivers. It passes four source clocks to their outputs: a CPU clock, a stoppable bus clock, a free-running bus clock and a fixed reference clock. Three active-low requests can silence some of these outputs. The CPU-stop request halts only the CPU output. The bus-stop request halts only the stoppable bus output. The power-down request halts all four outputs and drops a VCO-enable flag.

Every request is first captured on the rising edge of the free-running bus clock. The CPU stop is then carried through `CPU_SYNC_STAGES` flops in the CPU clock domain. Power-down is passed through `REF_SYNC_STAGES` flops into the reference domain. Each output has its own gate. The gate is a latch that is transparent only while its source clock is low, and the latch feeds an AND with the source clock. An output can therefore stop only in its low state, and it resumes only with a full high phase.

The CPU and bus clocks are assumed to be rising-edge aligned. The CPU clock is an integer multiple of the bus clock.

Top module: `clkStopCtrlTop`

## Requirements
- R1: While `rstN` is low, all four clock outputs, `vcoEn`, `cpuGateOpen` and `busGateOpen` read 0.
- R2: While power-down is high, `freeBusClkOut` and `refClkOut` keep toggling, whatever the levels of `stopCpuN` and `stopBusN`.
- R3: While the CPU stop is in force, `cpuClkOut` is held at logic 0 and shows no high pulse.
- R4: Let the capture edge be the first free-running bus rising edge that samples `stopCpuN` low. Call the CPU rising edges after it k = 1, 2, and so on. `cpuClkOut` still pulses for k <= `CPU_SYNC_STAGES` and is low from k = `CPU_SYNC_STAGES`+1 onward. The off latency is therefore 2 cycles with one stage and 3 cycles with two.
- R5: Release works the same way. Counted from the bus edge that samples `stopCpuN` high, `cpuClkOut` stays low for k <= `CPU_SYNC_STAGES` and pulses from k = `CPU_SYNC_STAGES`+1 onward.
- R6: When `stopBusN` is sampled low on a free-running bus rising edge, `busGateOpen` is 0 by the next such edge. `busClkOut` then stays low, while `cpuClkOut` and `freeBusClkOut` keep running.
- R7: When `pwrDownN` is low, all four outputs stay low. `vcoEn` is 0 from the free-running bus edge after the edge that sampled the low level. Power-down overrides both stop requests.
- R8: `cpuGateOpen` and `busGateOpen` read 1 exactly when the CPU and bus gates pass their clocks.
- R9: No output ever shows a high pulse shorter than the high phase of its source. This holds when a stop is applied or released and when power-down is released. A gate enable changes only while its source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of all control flops |
| cpuClkIn | input | 1 | Source CPU clock |
| busClkIn | input | 1 | Source stoppable bus clock, aligned to the free-running one |
| freeBusClkIn | input | 1 | Source free-running bus clock, used as the capture clock |
| refClkIn | input | 1 | Source fixed reference clock, asynchronous |
| stopCpuN | input | 1 | Active-low CPU clock stop request |
| stopBusN | input | 1 | Active-low bus clock stop request |
| pwrDownN | input | 1 | Active-low power-down request |
| cpuClkOut | output | 1 | Gated CPU clock |
| busClkOut | output | 1 | Gated bus clock |
| freeBusClkOut | output | 1 | Free-running bus clock, stopped only by power-down |
| refClkOut | output | 1 | Reference clock, stopped only by power-down |
| vcoEn | output | 1 | High when the synthesizer oscillators may run |
| cpuGateOpen | output | 1 | CPU gate currently passing its clock |
| busGateOpen | output | 1 | Bus gate currently passing its clock |

## Verification
The bench drives a CPU clock at three times the bus clock. It builds two copies of the block side by side: one with `CPU_SYNC_STAGES` = 1 and one with 2. The same stop and release pulses therefore exercise both ends of the two-to-three-cycle latency window, edge by edge. `REF_SYNC_STAGES` stays at 2. The reference clock runs at a period unrelated to the bus clock, so power-down release in that domain is seen from an asynchronous phase.

// File: rtl/clkStopPkg.sv
`timescale 1ns/1ps
package clkStopPkg;
  localparam int NUM_GATES = 4;
  localparam int IDX_REF   = 0;
  localparam int IDX_FREE  = 1;
  localparam int IDX_BUS   = 2;
  localparam int IDX_CPU   = 3;

  typedef struct packed {
    logic cpuEn;
    logic busEn;
    logic freeEn;
    logic refEn;
  } gateStrobes_t;
endpackage

// File: rtl/clkGateCell.sv
`timescale 1ns/1ps
module clkGateCell (
  input  logic clkIn,
  input  logic enIn,
  output logic clkOut,
  output logic enHeld
);
  logic enLat;

  // transparent only while the source is low, so enLat moves under a low output
  always_latch begin
    if (!clkIn) enLat = enIn;
  end

  assign clkOut = clkIn & enLat;
  assign enHeld = enLat;
endmodule

// File: rtl/clkGateBank.sv
`timescale 1ns/1ps
module clkGateBank
  import clkStopPkg::*;
(
  input  logic [NUM_GATES-1:0] clkIn,
  input  gateStrobes_t         strobes,
  output logic [NUM_GATES-1:0] clkOut,
  output logic [NUM_GATES-1:0] enHeld
);
  logic [NUM_GATES-1:0] enVec;

  assign enVec[IDX_CPU]  = strobes.cpuEn;
  assign enVec[IDX_BUS]  = strobes.busEn;
  assign enVec[IDX_FREE] = strobes.freeEn;
  assign enVec[IDX_REF]  = strobes.refEn;

  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    clkGateCell uCell (
      .clkIn (clkIn[g]),
      .enIn  (enVec[g]),
      .clkOut(clkOut[g]),
      .enHeld(enHeld[g])
    );
  end
endmodule

// File: rtl/clkStopSeq.sv
`timescale 1ns/1ps
module clkStopSeq
  import clkStopPkg::*;
#(
  parameter int CPU_SYNC_STAGES = 1,
  parameter int REF_SYNC_STAGES = 2
) (
  input  logic         rstN,
  input  logic         cpuClkIn,
  input  logic         freeBusClkIn,
  input  logic         refClkIn,
  input  logic         stopCpuN,
  input  logic         stopBusN,
  input  logic         pwrDownN,
  output gateStrobes_t strobes,
  output logic         vcoEn
);
  logic pdCap;
  logic cpuReqCap;
  logic busReqCap;
  logic [CPU_SYNC_STAGES-1:0] cpuPipe;
  logic [REF_SYNC_STAGES-1:0] refPipe;

  // capture point: rising edge of the free-running bus clock
  always_ff @(posedge freeBusClkIn or negedge rstN) begin
    if (!rstN) begin
      pdCap     <= 1'b0;
      cpuReqCap <= 1'b0;
      busReqCap <= 1'b0;
    end else begin
      pdCap     <= pwrDownN;
      cpuReqCap <= stopCpuN;
      busReqCap <= stopBusN;
    end
  end

  // aligned CPU domain: stage count sets the latency (stages + 1 cycles)
  always_ff @(posedge cpuClkIn or negedge rstN) begin
    if (!rstN) begin
      cpuPipe <= '0;
    end else begin
      cpuPipe[0] <= cpuReqCap & pdCap;
      for (int i = 1; i < CPU_SYNC_STAGES; i++) cpuPipe[i] <= cpuPipe[i-1];
    end
  end

  // asynchronous reference domain: plain multi-flop synchronizer
  always_ff @(posedge refClkIn or negedge rstN) begin
    if (!rstN) begin
      refPipe <= '0;
    end else begin
      refPipe[0] <= pdCap;
      for (int i = 1; i < REF_SYNC_STAGES; i++) refPipe[i] <= refPipe[i-1];
    end
  end

  assign strobes.cpuEn  = cpuPipe[CPU_SYNC_STAGES-1];
  assign strobes.busEn  = busReqCap & pdCap;
  assign strobes.freeEn = pdCap;
  assign strobes.refEn  = refPipe[REF_SYNC_STAGES-1];
  assign vcoEn          = pdCap;
endmodule

// File: rtl/clkStopCtrlTop.sv
`timescale 1ns/1ps
module clkStopCtrlTop
  import clkStopPkg::*;
#(
  parameter int CPU_SYNC_STAGES = 1,
  parameter int REF_SYNC_STAGES = 2
) (
  input  logic rstN,
  input  logic cpuClkIn,
  input  logic busClkIn,
  input  logic freeBusClkIn,
  input  logic refClkIn,
  input  logic stopCpuN,
  input  logic stopBusN,
  input  logic pwrDownN,
  output logic cpuClkOut,
  output logic busClkOut,
  output logic freeBusClkOut,
  output logic refClkOut,
  output logic vcoEn,
  output logic cpuGateOpen,
  output logic busGateOpen
);
  gateStrobes_t         strobes;
  logic [NUM_GATES-1:0] srcClk;
  logic [NUM_GATES-1:0] gatedClk;
  logic [NUM_GATES-1:0] enHeld;

  clkStopSeq #(
    .CPU_SYNC_STAGES(CPU_SYNC_STAGES),
    .REF_SYNC_STAGES(REF_SYNC_STAGES)
  ) uSeq (
    .rstN        (rstN),
    .cpuClkIn    (cpuClkIn),
    .freeBusClkIn(freeBusClkIn),
    .refClkIn    (refClkIn),
    .stopCpuN    (stopCpuN),
    .stopBusN    (stopBusN),
    .pwrDownN    (pwrDownN),
    .strobes     (strobes),
    .vcoEn       (vcoEn)
  );

  assign srcClk[IDX_CPU]  = cpuClkIn;
  assign srcClk[IDX_BUS]  = busClkIn;
  assign srcClk[IDX_FREE] = freeBusClkIn;
  assign srcClk[IDX_REF]  = refClkIn;

  clkGateBank uBank (
    .clkIn  (srcClk),
    .strobes(strobes),
    .clkOut (gatedClk),
    .enHeld (enHeld)
  );

  assign cpuClkOut     = gatedClk[IDX_CPU];
  assign busClkOut     = gatedClk[IDX_BUS];
  assign freeBusClkOut = gatedClk[IDX_FREE];
  assign refClkOut     = gatedClk[IDX_REF];
  assign cpuGateOpen   = enHeld[IDX_CPU];
  assign busGateOpen   = enHeld[IDX_BUS];
endmodule

// File: rtl/clkStopChecker.sv
`timescale 1ns/1ps
module clkStopChecker (
  input logic rstN,
  input logic cpuClkIn,
  input logic busClkIn,
  input logic freeBusClkIn,
  input logic pwrDownN,
  input logic stopBusN,
  input logic freeBusClkOut,
  input logic vcoEn,
  input logic cpuGateOpen,
  input logic busGateOpen
);
  // R9: gate enables move only under a low source clock
  always @(cpuGateOpen) begin
    if (rstN === 1'b1) p_cpu_gate_quiet_r9: assert (cpuClkIn == 1'b0);
  end
  always @(busGateOpen) begin
    if (rstN === 1'b1) p_bus_gate_quiet_r9: assert (busClkIn == 1'b0);
  end

  // R7: oscillator flag drops one capture edge after power-down is seen
  p_vco_off_r7: assert property (@(posedge freeBusClkIn) disable iff (!rstN)
    !pwrDownN |=> !vcoEn);

  // R7: sustained power-down closes the CPU gate
  p_pd_cpu_r7: assert property (@(posedge freeBusClkIn) disable iff (!rstN)
    (!pwrDownN && $past(!pwrDownN)) |=> !cpuGateOpen);

  // R6: bus stop closes the bus gate by the next capture edge
  p_bus_gate_r6: assert property (@(posedge freeBusClkIn) disable iff (!rstN)
    !stopBusN |=> !busGateOpen);

  // R2: the free-running output is high in every high phase once enabled
  p_free_runs_r2: assert property (@(negedge freeBusClkIn) disable iff (!rstN)
    $past(vcoEn) |-> freeBusClkOut);
endmodule

bind clkStopCtrlTop clkStopChecker uChk (
  .rstN         (rstN),
  .cpuClkIn     (cpuClkIn),
  .busClkIn     (busClkIn),
  .freeBusClkIn (freeBusClkIn),
  .pwrDownN     (pwrDownN),
  .stopBusN     (stopBusN),
  .freeBusClkOut(freeBusClkOut),
  .vcoEn        (vcoEn),
  .cpuGateOpen  (cpuGateOpen),
  .busGateOpen  (busGateOpen)
);

// File: tb/sim_clkStopCtrlTop.sv
`timescale 1ns/1ps
module pulseWidthMon #(parameter real MIN_W = 2.0) (
  input  logic sig,
  output int   runts,
  output int   rises
);
  realtime tRise;
  bit seen;
  initial begin runts = 0; rises = 0; seen = 0; tRise = 0; end
  always @(posedge sig) begin tRise = $realtime; seen = 1; rises++; end
  always @(negedge sig) if (seen && ($realtime - tRise) < MIN_W - 0.01) runts++;
endmodule

module sim_clkStopCtrlTop;
  localparam real HALF_CPU = 2.0;  // 250 MHz CPU clock
  localparam real HALF_REF = 3.5;

  logic cpuClk = 0, busClk = 0, refClk = 0, rstN = 0;
  logic stopCpuN = 1, stopBusN = 1, pwrDownN = 1;
  logic cpuOut0, busOut0, freeOut0, refOut0, vco0, cpuOpen0, busOpen0;
  logic cpuOut1, busOut1, freeOut1, refOut1, vco1, cpuOpen1, busOpen1;
  int checks = 0, failures = 0;
  int rCpu, rBus, rFree, rRef, rCpu1, rBus1, rFree1, rRef1;
  int nCpu, nBus, nFree, nRef, nCpu1, nBus1, nFree1, nRef1;

  clkStopCtrlTop #(.CPU_SYNC_STAGES(1)) u0 (
    .rstN(rstN), .cpuClkIn(cpuClk), .busClkIn(busClk), .freeBusClkIn(busClk),
    .refClkIn(refClk), .stopCpuN(stopCpuN), .stopBusN(stopBusN), .pwrDownN(pwrDownN),
    .cpuClkOut(cpuOut0), .busClkOut(busOut0), .freeBusClkOut(freeOut0),
    .refClkOut(refOut0), .vcoEn(vco0), .cpuGateOpen(cpuOpen0), .busGateOpen(busOpen0));

  clkStopCtrlTop #(.CPU_SYNC_STAGES(2)) u1 (
    .rstN(rstN), .cpuClkIn(cpuClk), .busClkIn(busClk), .freeBusClkIn(busClk),
    .refClkIn(refClk), .stopCpuN(stopCpuN), .stopBusN(stopBusN), .pwrDownN(pwrDownN),
    .cpuClkOut(cpuOut1), .busClkOut(busOut1), .freeBusClkOut(freeOut1),
    .refClkOut(refOut1), .vcoEn(vco1), .cpuGateOpen(cpuOpen1), .busGateOpen(busOpen1));

  pulseWidthMon #(.MIN_W(2.0)) mCpu  (.sig(cpuOut0),  .runts(rCpu),  .rises(nCpu));
  pulseWidthMon #(.MIN_W(6.0)) mBus  (.sig(busOut0),  .runts(rBus),  .rises(nBus));
  pulseWidthMon #(.MIN_W(6.0)) mFree (.sig(freeOut0), .runts(rFree), .rises(nFree));
  pulseWidthMon #(.MIN_W(3.5)) mRef  (.sig(refOut0),  .runts(rRef),  .rises(nRef));
  pulseWidthMon #(.MIN_W(2.0)) mCpu1 (.sig(cpuOut1),  .runts(rCpu1), .rises(nCpu1));
  pulseWidthMon #(.MIN_W(6.0)) mBus1 (.sig(busOut1),  .runts(rBus1), .rises(nBus1));
  pulseWidthMon #(.MIN_W(6.0)) mFre1 (.sig(freeOut1), .runts(rFree1), .rises(nFree1));
  pulseWidthMon #(.MIN_W(3.5)) mRef1 (.sig(refOut1),  .runts(rRef1), .rises(nRef1));

  // CPU clock at 3x the bus clock, rising edges aligned; bus high for 1.5 CPU periods
  initial begin
    #5;
    forever begin
      for (int ph = 0; ph < 3; ph++) begin
        cpuClk = 1; if (ph == 0) busClk = 1;
        #(HALF_CPU);
        cpuClk = 0; if (ph == 1) busClk = 0;
        #(HALF_CPU);
      end
    end
  end
  initial begin #1.3; forever #(HALF_REF) refClk = ~refClk; end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // vector bits: [6]=pwrDownN [5]=stopCpuN [4]=stopBusN
  //              [3]=cpu runs [2]=bus runs [1]=free+ref run [0]=vcoEn
  localparam logic [6:0] VEC [0:6] = '{
    7'b111_1111, 7'b101_0111, 7'b110_1011, 7'b100_0011,
    7'b011_0000, 7'b000_0000, 7'b111_1111 };

  task automatic walkVectors();
    int c0, b0, f0, r0;
    for (int v = 0; v < 7; v++) begin
      @(posedge busClk); #1;
      pwrDownN = VEC[v][6]; stopCpuN = VEC[v][5]; stopBusN = VEC[v][4];
      repeat (6) @(posedge busClk);
      #1;
      c0 = nCpu; b0 = nBus; f0 = nFree; r0 = nRef;
      repeat (3) @(posedge busClk);
      #1;
      check($sformatf("R3 vec%0d cpu toggling", v), logic'(nCpu != c0), VEC[v][3]);
      check($sformatf("R6 vec%0d bus toggling", v), logic'(nBus != b0), VEC[v][2]);
      check($sformatf("R2 vec%0d free toggling", v), logic'(nFree != f0), VEC[v][1]);
      check($sformatf("R2 vec%0d ref toggling", v), logic'(nRef != r0), VEC[v][1]);
      check($sformatf("R7 vec%0d vcoEn", v), vco0, VEC[v][0]);
      check($sformatf("R8 vec%0d cpuGateOpen", v), cpuOpen0, VEC[v][3]);
      check($sformatf("R8 vec%0d busGateOpen", v), busOpen0, VEC[v][2]);
      if (!VEC[v][6]) begin
        check($sformatf("R7 vec%0d cpu held low", v), cpuOut0, 1'b0);
        check($sformatf("R7 vec%0d free held low", v), freeOut0, 1'b0);
      end
    end
  endtask

  // stop (newLevel=0) or release (newLevel=1) the CPU clock and watch edges k=1..6
  task automatic cpuLatency(input logic newLevel);
    @(posedge busClk); #1;
    stopCpuN = newLevel;
    @(posedge busClk);  // capture edge
    for (int k = 1; k <= 6; k++) begin
      @(posedge cpuClk); #1;
      if (newLevel == 1'b0) begin
        check($sformatf("R4 off k=%0d stages=1", k), cpuOut0, logic'(k <= 1));
        check($sformatf("R4 off k=%0d stages=2", k), cpuOut1, logic'(k <= 2));
      end else begin
        check($sformatf("R5 on k=%0d stages=1", k), cpuOut0, logic'(k > 1));
        check($sformatf("R5 on k=%0d stages=2", k), cpuOut1, logic'(k > 2));
      end
    end
  endtask

  initial begin
    #30;
    // R1: reset state
    check("R1 cpuClkOut", cpuOut0, 1'b0);
    check("R1 busClkOut", busOut0, 1'b0);
    check("R1 freeBusClkOut", freeOut0, 1'b0);
    check("R1 refClkOut", refOut0, 1'b0);
    check("R1 vcoEn", vco0, 1'b0);
    check("R1 cpuGateOpen", cpuOpen0, 1'b0);
    check("R1 busGateOpen", busOpen0, 1'b0);
    @(posedge busClk); #1; rstN = 1;
    repeat (6) @(posedge busClk);

    walkVectors();

    cpuLatency(1'b0);
    // R3: stopped output reads low in high and low phases of its source
    for (int k = 0; k < 4; k++) begin
      @(posedge cpuClk); #1.5;
      check("R3 stopped high phase", cpuOut0, 1'b0);
      #2;
      check("R3 stopped low phase", cpuOut1, 1'b0);
    end
    cpuLatency(1'b1);

    // power-down asserted and released with stops pending, then stop during pd
    @(posedge busClk); #1; pwrDownN = 0; stopCpuN = 0;
    repeat (5) @(posedge busClk); #1;
    check("R7 priority cpu low", cpuOut1, 1'b0);
    stopCpuN = 1;
    repeat (2) @(posedge busClk); #1;
    check("R7 pd overrides released stop", cpuOpen0, 1'b0);
    pwrDownN = 1;
    repeat (8) @(posedge busClk); #1;
    check("R8 cpu gate reopens", cpuOpen1, 1'b1);

    // R9: no shortened high pulse on any output across all transitions
    checkInt("R9 runts u0", rCpu + rBus + rFree + rRef, 0);
    checkInt("R9 runts u1", rCpu1 + rBus1 + rFree1 + rRef1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule